// File: doc/BRIEF.md
# MSI Doorbell to Shared Interrupt Bridge

This block sits on a simple single-cycle register bus and turns message-signalled interrupt writes into shared peripheral interrupt (SPI) requests for a downstream interrupt controller. The address space is split into a power-of-two number of frames. Each frame spans 64 KB from its own base address, owns a private window of SPI numbers, and exposes three registers: a type word that describes its window, an identification word that encodes the total footprint, and a doorbell that a device writes with the SPI number it wants raised.

A doorbell write whose value falls inside the addressed frame's SPI window produces a one-clock request strobe with the 10-bit SPI number on the next cycle. Values outside the window, writes to any other register, and accesses that miss every frame are dropped without side effect. Reads return registered data one clock after the request. Frame bases, SPI bases and SPI counts are all parameters, and illegal configurations are flagged when the design is elaborated.

Top module: `msi_spi_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, `irq_valid`, `irq_num` and `bus_rdata` are all zero.
- R2: An access hits frame i when `FRAME_BASE[i] <= bus_addr < FRAME_BASE[i] + 0x10000`, with the frame offset being `bus_addr - FRAME_BASE[i]`. An access that hits no frame reads as zero and raises no interrupt.
- R3: A read at offset 0x008 returns the frame's SPI base in bits [31:16] and its SPI count in bits [15:0].
- R4: A read at offset 0xFD0 returns `0x4 | ((4 + log2(NUM_FRAMES)) << 4)`, which is 0x64 for four frames. The frame count must be a power of two.
- R5: A read at any other offset in a frame returns zero.
- R6: A write of value m at offset 0x040 with `SPI_BASE[i] <= m < SPI_BASE[i] + SPI_COUNT[i]` drives `irq_valid` high in the next cycle with `irq_num` equal to m. Every SPI base is at least 32.
- R7: A doorbell value below the frame's SPI base, at or above base plus count, or belonging only to another frame's window raises nothing.
- R8: Writes at offsets other than 0x040 raise nothing and leave every register's read value unchanged.
- R9: Read data appears in the cycle after the read request; in every cycle that does not follow a read, `bus_rdata` is zero.
- R10: `irq_valid` is high for exactly the cycles that follow accepted doorbell writes, so back-to-back accepted writes give back-to-back strobes and `irq_num` is zero whenever `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_valid | output | 1 | One-cycle SPI request strobe |
| irq_num | output | 10 | SPI number carried with the strobe |

## Verification
Doorbell writes are tried with values at both ends of each window, one below and one past the end, a value that belongs to another frame, and a value with high bits set that aliases into a window in its low bits; together these separate an exact range test from a truncated or off-by-one one. Register reads cover every frame plus the first and last words of a window and an address between frames, which shows whether frame selection and offset decode are independent. Writes to non-doorbell offsets followed by reads, and consecutive doorbells followed by idle cycles, show that stray writes leave no trace and that the strobe lasts exactly one cycle per accepted write.

// File: rtl/msi_bridge_pkg.sv
package msi_bridge_pkg;

    localparam int OFFSET_W   = 16;
    localparam int BUS_W      = 32;

    localparam logic [OFFSET_W-1:0] OFF_TYPE     = 16'h0008;
    localparam logic [OFFSET_W-1:0] OFF_DOORBELL = 16'h0040;
    localparam logic [OFFSET_W-1:0] OFF_IDENT    = 16'h0FD0;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_TYPE,
        REG_IDENT,
        REG_DOORBELL
    } reg_sel_e;

endpackage

// File: rtl/msi_frame_match.sv
module msi_frame_match #(
    parameter int NUM_FRAMES = 4,
    parameter int ADDR_W     = 32,
    parameter logic [NUM_FRAMES-1:0][ADDR_W-1:0] FRAME_BASE = '0,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [ADDR_W-1:0]                 addr,
    output logic                              hit,
    output logic [IDX_W-1:0]                  frame_idx,
    output logic [msi_bridge_pkg::OFFSET_W-1:0] offset
);
    import msi_bridge_pkg::*;

    logic [NUM_FRAMES-1:0]              frame_hit;
    logic [NUM_FRAMES-1:0][ADDR_W-1:0]  frame_diff;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        always_comb begin
            frame_diff[g] = addr - FRAME_BASE[g];
            frame_hit[g]  = (addr >= FRAME_BASE[g]) &&
                            (frame_diff[g][ADDR_W-1:OFFSET_W] == '0);
        end
    end

    // lowest index wins when windows overlap
    always_comb begin
        hit       = 1'b0;
        frame_idx = '0;
        offset    = '0;
        for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
            if (frame_hit[i]) begin
                hit       = 1'b1;
                frame_idx = IDX_W'(i);
                offset    = frame_diff[i][OFFSET_W-1:0];
            end
        end
    end

endmodule

// File: rtl/msi_reg_decode.sv
module msi_reg_decode (
    input  logic                                hit,
    input  logic [msi_bridge_pkg::OFFSET_W-1:0] offset,
    output msi_bridge_pkg::reg_sel_e            sel
);
    import msi_bridge_pkg::*;

    always_comb begin
        sel = REG_NONE;
        if (hit) begin
            unique case (offset)
                OFF_TYPE:     sel = REG_TYPE;
                OFF_IDENT:    sel = REG_IDENT;
                OFF_DOORBELL: sel = REG_DOORBELL;
                default:      sel = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/msi_spi_window.sv
module msi_spi_window #(
    parameter int NUM_FRAMES = 4,
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_BASE  = '0,
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_COUNT = '0,
    localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic [IDX_W-1:0]                     frame_idx,
    input  logic [msi_bridge_pkg::BUS_W-1:0]     value,
    output logic                                 in_window,
    output logic [msi_bridge_pkg::BUS_W-1:0]     type_word
);
    import msi_bridge_pkg::*;

    logic [NUM_FRAMES-1:0]            frame_ok;
    logic [NUM_FRAMES-1:0][BUS_W-1:0] frame_type;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_win
        localparam logic [BUS_W-1:0] LO = BUS_W'(SPI_BASE[g]);
        localparam logic [BUS_W-1:0] HI = BUS_W'(SPI_BASE[g]) + BUS_W'(SPI_COUNT[g]);
        always_comb begin
            frame_ok[g]   = (value >= LO) && (value < HI);
            frame_type[g] = {SPI_BASE[g], SPI_COUNT[g]};
        end
    end

    always_comb begin
        in_window = frame_ok[frame_idx];
        type_word = frame_type[frame_idx];
    end

endmodule

// File: rtl/msi_spi_bridge.sv
module msi_spi_bridge #(
    parameter int NUM_FRAMES = 4,
    parameter int ADDR_W     = 32,
    parameter int SPI_W      = 10,
    parameter logic [NUM_FRAMES-1:0][ADDR_W-1:0] FRAME_BASE =
        {32'h2008_0000, 32'h2004_0000, 32'h2001_0000, 32'h2000_0000},
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_BASE  =
        {16'd190, 16'd150, 16'd100, 16'd320},
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_COUNT =
        {16'd8, 16'd16, 16'd32, 16'd64}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [31:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_valid,
    output logic [SPI_W-1:0]  irq_num
);
    import msi_bridge_pkg::*;

    localparam int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
    localparam int LOG2_FRAMES = $clog2(NUM_FRAMES);
    localparam logic [BUS_W-1:0] IDENT_WORD = 32'h4 | (BUS_W'(4 + LOG2_FRAMES) << 4);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             irq_valid;
        logic [SPI_W-1:0] irq_num;
    } bridge_state_t;

    bridge_state_t state_d, state_q;

    logic                  hit;
    logic [IDX_W-1:0]      frame_idx;
    logic [OFFSET_W-1:0]   offset;
    reg_sel_e              sel;
    logic                  in_window;
    logic [BUS_W-1:0]      type_word;

    msi_frame_match #(
        .NUM_FRAMES (NUM_FRAMES),
        .ADDR_W     (ADDR_W),
        .FRAME_BASE (FRAME_BASE)
    ) u_match (
        .addr      (bus_addr[ADDR_W-1:0]),
        .hit       (hit),
        .frame_idx (frame_idx),
        .offset    (offset)
    );

    msi_reg_decode u_decode (
        .hit    (hit),
        .offset (offset),
        .sel    (sel)
    );

    msi_spi_window #(
        .NUM_FRAMES (NUM_FRAMES),
        .SPI_BASE   (SPI_BASE),
        .SPI_COUNT  (SPI_COUNT)
    ) u_window (
        .frame_idx (frame_idx),
        .value     (bus_wdata),
        .in_window (in_window),
        .type_word (type_word)
    );

    always_comb begin
        state_d = '0;
        if (bus_req) begin
            if (!bus_we) begin
                unique case (sel)
                    REG_TYPE:  state_d.rdata = type_word;
                    REG_IDENT: state_d.rdata = IDENT_WORD;
                    default:   state_d.rdata = '0;
                endcase
            end else if ((sel == REG_DOORBELL) && in_window) begin
                state_d.irq_valid = 1'b1;
                state_d.irq_num   = bus_wdata[SPI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign irq_valid = state_q.irq_valid;
    assign irq_num   = state_q.irq_num;

endmodule

// File: rtl/msi_spi_bridge_checker.sv
module msi_spi_bridge_checker #(
    parameter int NUM_FRAMES = 4,
    parameter int SPI_W      = 10,
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_BASE  = '0,
    parameter logic [NUM_FRAMES-1:0][15:0] SPI_COUNT = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             irq_valid,
    input logic [SPI_W-1:0] irq_num
);

    initial begin
        assert_cfg_pow2_R4: assert ((NUM_FRAMES > 0) && ((NUM_FRAMES & (NUM_FRAMES - 1)) == 0))
            else $error("frame count must be a power of two");
        for (int i = 0; i < NUM_FRAMES; i++) begin
            assert_cfg_spi_base_R6: assert (SPI_BASE[i] >= 16'd32)
                else $error("SPI base of frame %0d below 32", i);
            assert_cfg_spi_fit_R6: assert ((32'(SPI_BASE[i]) + 32'(SPI_COUNT[i])) <= (32'd1 << SPI_W))
                else $error("SPI window of frame %0d exceeds number width", i);
        end
    end

    logic num_in_some_window;
    always_comb begin
        num_in_some_window = 1'b0;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            if ((32'(irq_num) >= 32'(SPI_BASE[i])) &&
                (32'(irq_num) <  32'(SPI_BASE[i]) + 32'(SPI_COUNT[i])))
                num_in_some_window = 1'b1;
        end
    end

    assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(bus_req && bus_we));

    assert_irq_num_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_num == $past(bus_wdata[SPI_W-1:0])));

    assert_irq_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> num_in_some_window);

    assert_num_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_num == '0));

    assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_req && !bus_we) |-> (bus_rdata == 32'h0));

    assert_no_irq_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_req && !bus_we) |-> !irq_valid);

endmodule

bind msi_spi_bridge msi_spi_bridge_checker #(
    .NUM_FRAMES (NUM_FRAMES),
    .SPI_W      (SPI_W),
    .SPI_BASE   (SPI_BASE),
    .SPI_COUNT  (SPI_COUNT)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_valid (irq_valid),
    .irq_num   (irq_num)
);

// File: tb/msi_spi_bridge_test.sv
`timescale 1ns/1ps
module msi_spi_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [9:0]  irq_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench's own view of the default configuration
    longint frame_base [4] = '{64'h2000_0000, 64'h2001_0000, 64'h2004_0000, 64'h2008_0000};
    longint spi_lo     [4] = '{320, 100, 150, 190};
    longint spi_cnt    [4] = '{64, 32, 16, 8};

    always #2 clk = ~clk;

    msi_spi_bridge uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_valid (irq_valid),
        .irq_num   (irq_num)
    );

    function automatic int find_frame(input longint a);
        for (int i = 0; i < 4; i++)
            if (a >= frame_base[i] && a < frame_base[i] + 65536) return i;
        return -1;
    endfunction

    task automatic step(input bit req, input bit we, input logic [31:0] addr,
                        input logic [31:0] data, input string tag);
        int      f;
        longint  off;
        longint  m;
        logic [31:0] e_rd;
        logic        e_v;
        logic [9:0]  e_n;
        bus_req = req; bus_we = we; bus_addr = addr; bus_wdata = data;
        e_rd = '0; e_v = 1'b0; e_n = '0;
        f = find_frame(longint'(addr));
        if (req && f >= 0) begin
            off = longint'(addr) - frame_base[f];
            m   = longint'(data);
            if (!we) begin
                if (off == 'h008) e_rd = 32'((spi_lo[f] << 16) | spi_cnt[f]);
                else if (off == 'hFD0) e_rd = 32'h64;
            end else if (off == 'h040 && m >= spi_lo[f] && m < spi_lo[f] + spi_cnt[f]) begin
                e_v = 1'b1;
                e_n = 10'(m);
            end
        end
        @(negedge clk);
        checks++;
        if (bus_rdata !== e_rd || irq_valid !== e_v || irq_num !== e_n) begin
            errors++;
            $display("FAIL %s: rdata=%h valid=%b num=%0d expected rdata=%h valid=%b num=%0d",
                     tag, bus_rdata, irq_valid, irq_num, e_rd, e_v, e_n);
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 1'b0, 32'h0, 32'h0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h0 || irq_valid !== 1'b0 || irq_num !== 10'h0) begin
            errors++;
            $display("FAIL R1: rdata=%h valid=%b num=%0d expected all zero",
                     bus_rdata, irq_valid, irq_num);
        end
        rst_n = 1'b1;
        idle("R1 first cycle after reset");

        // R3 type register of every frame
        step(1, 0, 32'h2000_0008, 0, "R3 type frame0");
        step(1, 0, 32'h2001_0008, 0, "R3 type frame1");
        step(1, 0, 32'h2004_0008, 0, "R3 type frame2");
        step(1, 0, 32'h2008_0008, 0, "R3 type frame3");
        // R4 identification register
        step(1, 0, 32'h2000_0FD0, 0, "R4 ident frame0");
        step(1, 0, 32'h2008_0FD0, 0, "R4 ident frame3");
        // R5 other offsets
        step(1, 0, 32'h2000_0000, 0, "R5 offset 0");
        step(1, 0, 32'h2001_0040, 0, "R5 doorbell read");
        step(1, 0, 32'h2004_0FD4, 0, "R5 offset fd4");
        step(1, 0, 32'h2000_FFFC, 0, "R5 last word of window");
        // R2 frame windows
        step(1, 0, 32'h2002_0008, 0, "R2 gap between frames");
        step(1, 0, 32'h1FFF_0008, 0, "R2 below first frame");
        step(1, 1, 32'h2003_0040, 32'd100, "R2 doorbell in gap");
        step(1, 0, 32'h2001_0008, 0, "R2 first frame after boundary");
        // R9 read latency and quiet cycles
        idle("R9 idle after read");
        step(1, 0, 32'h2004_0008, 0, "R9 read");
        step(1, 1, 32'h2004_0008, 32'hFFFF_FFFF, "R9 write after read");

        // R6 accepted doorbells
        step(1, 1, 32'h2000_0040, 32'd320, "R6 frame0 low edge");
        step(1, 1, 32'h2000_0040, 32'd383, "R6 frame0 high edge");
        step(1, 1, 32'h2001_0040, 32'd100, "R6 frame1 low edge");
        step(1, 1, 32'h2008_0040, 32'd197, "R6 frame3 high edge");
        idle("R10 strobe ends");
        // R7 dropped values
        step(1, 1, 32'h2000_0040, 32'd384, "R7 one past end");
        step(1, 1, 32'h2000_0040, 32'd319, "R7 one below base");
        step(1, 1, 32'h2000_0040, 32'd100, "R7 other frame value");
        step(1, 1, 32'h2008_0040, 32'd198, "R7 frame3 past end");
        step(1, 1, 32'h2004_0040, 32'h0001_0096, "R7 high bits alias");
        step(1, 1, 32'h2004_0040, 32'd31, "R7 below SPI range");
        // R8 writes elsewhere
        step(1, 1, 32'h2000_0008, 32'd330, "R8 write type reg");
        step(1, 1, 32'h2000_0FD0, 32'd330, "R8 write ident reg");
        step(1, 1, 32'h2000_0044, 32'd330, "R8 write near doorbell");
        step(1, 0, 32'h2000_0008, 0, "R8 type unchanged");
        step(1, 0, 32'h2000_0FD0, 0, "R8 ident unchanged");
        // R10 back-to-back strobes
        step(1, 1, 32'h2004_0040, 32'd150, "R10 burst first");
        step(1, 1, 32'h2004_0040, 32'd165, "R10 burst second");
        step(1, 1, 32'h2001_0040, 32'd131, "R10 burst third");
        step(0, 1, 32'h2001_0040, 32'd131, "R10 no request");
        idle("R10 idle");

        // R1 reset mid-stream
        step(1, 0, 32'h2000_0008, 0, "R1 read before reset");
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 32'h2000_0040; bus_wdata = 32'd321;
        rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h0 || irq_valid !== 1'b0 || irq_num !== 10'h0) begin
            errors++;
            $display("FAIL R1 reset mid-stream: rdata=%h valid=%b num=%0d expected all zero",
                     bus_rdata, irq_valid, irq_num);
        end
        bus_req = 1'b0; bus_we = 1'b0;
        rst_n = 1'b1;
        idle("R1 after second reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule